// File: doc/BRIEF.md
# ARINC 429 Receive Word Buffer

This block sits behind the serial decoders of a multi-channel ARINC 429 receiver. Each decoder hands over a finished 32-bit word together with a one-cycle end-of-word strobe. For each channel, the block does four things:

- It checks the word against an optional two-bit filter on ARINC bits 9 and 10.
- It replaces bit 32 with a parity verdict.
- It holds the result in a latch.
- It pulls that channel's active-low ready flag low.

A host reads a held word as two 16-bit halves over one shared data bus. Each channel has its own active-low read enable, and a single half-select input picks the half. Once both halves of a word have been read, the ready flag returns high.

Each channel keeps its own latch, filter setting and read-progress record. The read path is shared and gives fixed priority to the lowest-numbered channel. A word that arrives before the previous one has been fully read replaces it.

Top module: `a429_rx_word_buffer`

## Requirements
- R1: When `filt_en[k]` is 1, an end-of-word strobe on channel k is accepted only if word bit index 8 (ARINC bit 9) equals `filt_code[k][0]` and index 9 (ARINC bit 10) equals `filt_code[k][1]`. A rejected strobe leaves the latch and `rdy_n[k]` unchanged. When `filt_en[k]` is 0, every strobe is accepted.
- R2: An accepted strobe loads the channel latch at that clock edge and drives `rdy_n[k]` low from that edge on.
- R3: `rdy_n[k]` stays low until both halves of the held word have been read, in either order.
  - A read of channel k ends when `rd_en_n[k]` is seen high at a clock edge after it was seen low at the previous edge.
  - The half that was read is the `half_sel` value at that previous edge.
  - `rdy_n[k]` goes high at the edge that ends the second distinct half. Repeated reads of the same half do not count.
- R4: While a channel drives the bus, `half_sel`=0 puts word bits 15:0 (ARINC bits 1 to 16, bit 1 at data bit 0) on `data_o`. `half_sel`=1 puts bits 31:16 on `data_o`.
- R5: Stored bit 31 (ARINC bit 32, `data_o[15]` of the upper half) is 1 when the 32 received bits hold an even number of ones, and 0 when they hold an odd number.
- R6: An accepted strobe while a word is still unread overwrites the latch and clears the record of halves already read. A strobe wins over a read that ends at the same edge.
- R7: With every `rd_en_n` high, `data_o` is all zeros and `data_oe` is 0. With any `rd_en_n` low, `data_oe` is 1.
- R8: If several enables are low, the lowest channel index drives the bus. A read counts only for a channel that held the bus at the last edge before its enable rose.
- R9: After reset every `rdy_n` bit is 1 and every latch holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eos | input | NCH (2) | One-cycle end-of-word strobe per channel |
| rx_word | input | NCH x 32 | Received word per channel, index 0 is ARINC bit 1 |
| filt_en | input | NCH (2) | Per-channel filter enable on bits 9 and 10 |
| filt_code | input | NCH x 2 | Per-channel expected value of bits 10 and 9 |
| rd_en_n | input | NCH (2) | Active-low read enable per channel |
| half_sel | input | 1 | Half select: 0 lower half, 1 upper half |
| data_o | output | 16 | Shared read data |
| data_oe | output | 1 | High while some channel drives data_o |
| rdy_n | output | NCH (2) | Active-low word-ready flag per channel |

## Verification
The bench reads the upper half first, reads the same half twice, and overwrites a word between its two half reads. A design that tracked reads in a fixed order, counted read pulses, or kept the stale half record would release the ready flag early or late in these cases. Filter mismatches test that a rejected word neither touches the latch nor lowers ready. Words with odd and even ones counts test that bit 32 reports parity in the right sense. Overlapping enables test that the second channel neither gets the bus nor has its read counted.

// File: rtl/a429_buf_pkg.sv
package a429_buf_pkg;
   localparam int unsigned A429_WORD_W = 32;
   localparam int unsigned A429_HALF_W = 16;
   localparam int unsigned A429_FILT_LSB = 8;   // ARINC bit 9
   localparam int unsigned A429_FILT_W = 2;

   typedef enum logic [0:0] {
      HALF_LOW  = 1'b0,
      HALF_HIGH = 1'b1
   } half_e;

   // Stored parity verdict: 1 when the ones count is even.
   function automatic logic even_ones(input logic [A429_WORD_W-1:0] w);
      return ~(^w);
   endfunction
endpackage

// File: rtl/a429_word_gate.sv
module a429_word_gate
   import a429_buf_pkg::*;
#(
   parameter int unsigned WORD_W   = A429_WORD_W,
   parameter int unsigned FILT_LSB = A429_FILT_LSB,
   parameter int unsigned FILT_W   = A429_FILT_W,
   parameter bit          PAR_FLAG = 1'b1
) (
   input  logic              strobe,
   input  logic [WORD_W-1:0] word_in,
   input  logic              filt_on,
   input  logic [FILT_W-1:0] filt_val,
   output logic              accept,
   output logic [WORD_W-1:0] word_out
);
   localparam int unsigned FILT_MSB = FILT_LSB + FILT_W - 1;

   generate
      if (FILT_MSB >= WORD_W) begin : g_bad_filt
         $error("filter field lies outside the word");
      end
   endgenerate

   logic field_hit;
   assign field_hit = (word_in[FILT_MSB:FILT_LSB] == filt_val);
   assign accept    = strobe & (~filt_on | field_hit);

   generate
      if (PAR_FLAG) begin : g_par_flag
         assign word_out = {even_ones(word_in), word_in[WORD_W-2:0]};
      end else begin : g_par_raw
         assign word_out = word_in;
      end
   endgenerate
endmodule

// File: rtl/a429_word_hold.sv
module a429_word_hold #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned HALF_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   input  logic              rd_end,
   input  logic [$clog2(WORD_W/HALF_W)-1:0] rd_half,
   output logic [WORD_W-1:0] word_q,
   output logic              rdy_n
);
   localparam int unsigned NHALF = WORD_W / HALF_W;

   logic [NHALF-1:0] seen_q;
   logic [NHALF-1:0] seen_nxt;

   always_comb begin
      seen_nxt = seen_q;
      seen_nxt[rd_half] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         rdy_n  <= 1'b1;
         seen_q <= '0;
      end else if (load) begin
         word_q <= load_word;
         rdy_n  <= 1'b0;
         seen_q <= '0;
      end else if (rd_end && !rdy_n) begin
         if (&seen_nxt) begin
            rdy_n  <= 1'b1;
            seen_q <= '0;
         end else begin
            seen_q <= seen_nxt;
         end
      end
   end
endmodule

// File: rtl/a429_half_mux.sv
module a429_half_mux #(
   parameter int unsigned NCH    = 2,
   parameter int unsigned WORD_W = 32,
   parameter int unsigned HALF_W = 16
) (
   input  logic [NCH-1:0]              en_n,
   input  logic [$clog2(WORD_W/HALF_W)-1:0] sel,
   input  logic [NCH-1:0][WORD_W-1:0]  words,
   output logic [NCH-1:0]              gnt,
   output logic [HALF_W-1:0]           data,
   output logic                        oe
);
   always_comb begin
      gnt  = '0;
      data = '0;
      for (int k = NCH - 1; k >= 0; k--) begin
         if (!en_n[k]) begin
            gnt  = '0;
            gnt[k] = 1'b1;
            data = words[k][sel*HALF_W +: HALF_W];
         end
      end
   end

   assign oe = ~(&en_n);
endmodule

// File: rtl/a429_rx_word_buffer.sv
module a429_rx_word_buffer
   import a429_buf_pkg::*;
#(
   parameter int unsigned NCH      = 2,
   parameter int unsigned WORD_W   = A429_WORD_W,
   parameter int unsigned HALF_W   = A429_HALF_W,
   parameter int unsigned FILT_LSB = A429_FILT_LSB,
   parameter bit          PAR_FLAG = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NCH-1:0]             eos,
   input  logic [NCH-1:0][WORD_W-1:0] rx_word,
   input  logic [NCH-1:0]             filt_en,
   input  logic [NCH-1:0][A429_FILT_W-1:0] filt_code,
   input  logic [NCH-1:0]             rd_en_n,
   input  logic [$clog2(WORD_W/HALF_W)-1:0] half_sel,
   output logic [HALF_W-1:0]          data_o,
   output logic                       data_oe,
   output logic [NCH-1:0]             rdy_n
);
   localparam int unsigned NHALF = WORD_W / HALF_W;
   localparam int unsigned SEL_W = $clog2(NHALF);

   generate
      if (NCH < 1) begin : g_bad_nch
         $error("NCH must be at least 1");
      end
      if (NHALF * HALF_W != WORD_W || NHALF < 2) begin : g_bad_half
         $error("WORD_W must be a multiple of HALF_W, at least twice");
      end
   endgenerate

   logic [NCH-1:0][WORD_W-1:0] held;
   logic [NCH-1:0]             gnt;
   logic [NCH-1:0]             gnt_q;
   logic [SEL_W-1:0]           sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_q <= '0;
         sel_q <= '0;
      end else begin
         gnt_q <= gnt;
         sel_q <= half_sel;
      end
   end

   generate
      for (genvar k = 0; k < NCH; k++) begin : g_ch
         logic              acc;
         logic [WORD_W-1:0] fixed;
         logic              rd_end;

         assign rd_end = gnt_q[k] & rd_en_n[k];

         a429_word_gate #(
            .WORD_W  (WORD_W),
            .FILT_LSB(FILT_LSB),
            .FILT_W  (A429_FILT_W),
            .PAR_FLAG(PAR_FLAG)
         ) u_gate (
            .strobe  (eos[k]),
            .word_in (rx_word[k]),
            .filt_on (filt_en[k]),
            .filt_val(filt_code[k]),
            .accept  (acc),
            .word_out(fixed)
         );

         a429_word_hold #(
            .WORD_W(WORD_W),
            .HALF_W(HALF_W)
         ) u_hold (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (acc),
            .load_word(fixed),
            .rd_end   (rd_end),
            .rd_half  (sel_q),
            .word_q   (held[k]),
            .rdy_n    (rdy_n[k])
         );
      end
   endgenerate

   a429_half_mux #(
      .NCH   (NCH),
      .WORD_W(WORD_W),
      .HALF_W(HALF_W)
   ) u_mux (
      .en_n (rd_en_n),
      .sel  (half_sel),
      .words(held),
      .gnt  (gnt),
      .data (data_o),
      .oe   (data_oe)
   );
endmodule

// File: rtl/a429_rx_word_buffer_chk.sv
module a429_rx_word_buffer_chk
   import a429_buf_pkg::*;
#(
   parameter int unsigned NCH      = 2,
   parameter int unsigned WORD_W   = A429_WORD_W,
   parameter int unsigned HALF_W   = A429_HALF_W,
   parameter int unsigned FILT_LSB = A429_FILT_LSB
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [NCH-1:0]             eos,
   input logic [NCH-1:0][WORD_W-1:0] rx_word,
   input logic [NCH-1:0]             filt_en,
   input logic [NCH-1:0][A429_FILT_W-1:0] filt_code,
   input logic [NCH-1:0]             rd_en_n,
   input logic [HALF_W-1:0]          data_o,
   input logic                       data_oe,
   input logic [NCH-1:0]             rdy_n
);
   p_idle_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (&rd_en_n) |-> (!data_oe && data_o == '0));

   p_any_en_drives_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en_n[0]) |-> data_oe);

   generate
      for (genvar k = 0; k < NCH; k++) begin : g_c
         logic match;
         assign match = (rx_word[k][FILT_LSB +: A429_FILT_W] == filt_code[k]);

         p_accept_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (eos[k] && (!filt_en[k] || match)) |=> !rdy_n[k]);

         p_reject_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (eos[k] && filt_en[k] && !match && rdy_n[k]) |=> rdy_n[k]);

         p_release_no_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rdy_n[k]) |-> !$past(eos[k] && (!filt_en[k] || match)));

         p_release_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rdy_n[k]) |-> $past(rd_en_n[k]));
      end
   endgenerate
endmodule

bind a429_rx_word_buffer a429_rx_word_buffer_chk #(
   .NCH     (NCH),
   .WORD_W  (WORD_W),
   .HALF_W  (HALF_W),
   .FILT_LSB(FILT_LSB)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .eos      (eos),
   .rx_word  (rx_word),
   .filt_en  (filt_en),
   .filt_code(filt_code),
   .rd_en_n  (rd_en_n),
   .data_o   (data_o),
   .data_oe  (data_oe),
   .rdy_n    (rdy_n)
);

// File: tb/a429_rx_word_buffer_bench.sv
module a429_rx_word_buffer_bench;
   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       eos = '0;
   logic [1:0][31:0] rx_word = '0;
   logic [1:0]       filt_en = '0;
   logic [1:0][1:0]  filt_code = '0;
   logic [1:0]       rd_en_n = 2'b11;
   logic [0:0]       half_sel = '0;
   logic [15:0]      data_o;
   logic             data_oe;
   logic [1:0]       rdy_n;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   logic [31:0] m_word [2];
   bit          m_pend [2];
   bit [1:0]    m_seen [2];

   always #10 clk = ~clk;

   a429_rx_word_buffer u_a429_rx_word_buffer (
      .clk(clk), .rst_n(rst_n), .eos(eos), .rx_word(rx_word),
      .filt_en(filt_en), .filt_code(filt_code), .rd_en_n(rd_en_n),
      .half_sel(half_sel), .data_o(data_o), .data_oe(data_oe), .rdy_n(rdy_n)
   );

   function automatic logic [31:0] fixw(input logic [31:0] w);
      return {~(^w), w[30:0]};
   endfunction

   function automatic bit passes(input logic [31:0] w, input bit en, input logic [1:0] c);
      return !en || (w[9:8] == c);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_rdy(input string tag);
      chk(rdy_n == {!m_pend[1], !m_pend[0]}, tag, rdy_n, {!m_pend[1], !m_pend[0]});
   endtask

   task automatic send(input int ch, input logic [31:0] w, input bit en, input logic [1:0] c);
      @(negedge clk);
      eos[ch] = 1'b1; rx_word[ch] = w; filt_en[ch] = en; filt_code[ch] = c;
      @(negedge clk);
      eos[ch] = 1'b0;
      if (passes(w, en, c)) begin
         m_word[ch] = fixw(w); m_pend[ch] = 1'b1; m_seen[ch] = 2'b00;
      end
   endtask

   task automatic read_half(input int ch, input bit sel, input string tag);
      logic [15:0] exp;
      @(negedge clk);
      half_sel = sel; rd_en_n[ch] = 1'b0;
      #1;
      exp = sel ? m_word[ch][31:16] : m_word[ch][15:0];
      chk(data_o == exp && data_oe, tag, {15'd0, data_oe, data_o}, {16'd1, exp});
      @(negedge clk);
      rd_en_n[ch] = 1'b1;
      @(negedge clk);
      if (m_pend[ch]) begin
         m_seen[ch][sel] = 1'b1;
         if (&m_seen[ch]) begin m_pend[ch] = 1'b0; m_seen[ch] = 2'b00; end
      end
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4290));
      for (int i = 0; i < 2; i++) begin m_word[i] = '0; m_pend[i] = 0; m_seen[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state, R7 idle bus
      chk(rdy_n == 2'b11, "R9 rdy after reset", rdy_n, 2'b11);
      chk(data_o == 0 && !data_oe, "R7 idle bus", {data_oe, data_o}, 0);
      read_half(0, 0, "R9 latch zero");

      // R2 R4 R3: lower then upper
      send(0, 32'h1234_5601, 0, 0);
      chk_rdy("R2 ready low on accept");
      read_half(0, 0, "R4 lower half");
      chk_rdy("R3 still low after one half");
      read_half(0, 1, "R4 upper half");
      chk_rdy("R3 release after both");

      // R3 upper first, same half twice
      send(1, 32'h8000_0003, 0, 0);
      read_half(1, 1, "R4 upper first");
      read_half(1, 1, "R3 repeat upper");
      chk_rdy("R3 repeat half does not release");
      read_half(1, 0, "R4 lower last");
      chk_rdy("R3 release upper-first order");

      // R5 parity: odd count -> bit 31 cleared, even -> set
      send(0, 32'h0000_0001, 0, 0);
      read_half(0, 1, "R5 odd ones gives 0");
      read_half(0, 0, "R5 lower");
      send(0, 32'h8000_0001, 0, 0);
      read_half(0, 1, "R5 even ones gives 1");
      read_half(0, 0, "R5 lower even");

      // R1 filter reject and accept
      send(0, 32'h0000_0100, 1, 2'b10);
      chk_rdy("R1 mismatch rejected");
      read_half(0, 0, "R1 latch kept after reject");
      send(0, 32'h0000_0200, 1, 2'b10);
      chk_rdy("R1 match accepted");

      // R6 overwrite after one half read
      read_half(0, 0, "R6 first half old word");
      send(0, 32'hCAFE_BEEF, 0, 0);
      read_half(0, 1, "R6 new upper");
      chk_rdy("R6 half record cleared");
      read_half(0, 0, "R6 new lower");
      chk_rdy("R6 release after new halves");

      // R8 priority with overlapping enables
      send(0, 32'h1111_2222, 0, 0);
      send(1, 32'h3333_4444, 0, 0);
      @(negedge clk);
      half_sel = 1'b0; rd_en_n = 2'b00;
      #1;
      chk(data_o == m_word[0][15:0], "R8 channel 1 wins bus", data_o, m_word[0][15:0]);
      @(negedge clk);
      rd_en_n = 2'b11;
      @(negedge clk);
      m_seen[0][0] = 1'b1;
      read_half(1, 1, "R8 second channel upper");
      chk_rdy("R8 losing read not counted");
      read_half(0, 1, "R8 ch1 upper");
      read_half(1, 0, "R8 ch2 lower");
      chk_rdy("R8 both released");

      // random mix
      for (int it = 0; it < 400; it++) begin
         int ch;
         int op;
         ch = int'($urandom % 2);
         op = int'($urandom % 3);
         if (op == 0) begin
            send(ch, $urandom, 1'($urandom % 2), 2'($urandom));
            chk_rdy("R1 R2 random send");
         end else begin
            read_half(ch, 1'($urandom % 2), "R4 random read");
            chk_rdy("R3 random read");
         end
      end

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule